// File: doc/BRIEF.md
# Programmable Interrupt Pin Generator

This block turns single-cycle event strobes from two groups, general bus events and DMA events, into one interrupt pin. Each event sets a sticky bit in a status register for its group. Software clears a bit by writing a one to it. A per-group enable mask selects which logged bits can raise a request. The request is the OR of all enabled, logged bits. It reaches the pin only while a global enable bit is set.

The pin has two signalling styles. In level mode it follows the request. In pulse mode it emits a fixed-width pulse once for each rising edge of the request. Its active level is programmable, and the idle level is always the inverse of the active level. After reset the pin idles high, is active low and runs in level mode.

Software reaches the registers through a simple synchronous bus. A write is taken on the clock edge where select and write are both high. Read data follows the address combinationally.

Top module: `irq_pin_gen`

## Requirements
- R1: After reset the pin is high (idle, active-low polarity, level mode), and every register reads 0.
- R2: An event strobe on bus bit i sets bit i of the bus status register (offset 0x18). An event strobe on DMA bit i sets bit i of the DMA status register (offset 0x20). The bit is readable after the edge that samples the strobe.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An event in the same cycle as a clear of the same bit leaves the bit set.
- R4: A status bit whose enable bit is 0 does not drive the pin. The enables are bus mask 0x14 and DMA mask 0x1C, with bit i gating status bit i.
- R5: The pin stays idle while the global enable (offset 0x0C, bit 0) is 0. Clearing the enable returns the pin to idle one cycle after the write edge.
- R6: In level mode (config bit 1 = 0) the pin is active from one cycle after the request rises until one cycle after the last enabled status bit clears.
- R7: In pulse mode (config bit 1 = 1) a rising request produces exactly PULSE_CYC active cycles, starting one cycle after the request rises.
- R8: In pulse mode, no further pulse is generated while the request stays high. A new pulse follows only after the request has returned to 0 and risen again.
- R9: Config bit 0 selects polarity (1 = active high, 0 = active low). A polarity write changes the pin right after the write edge.
- R10: Mode register is at offset 0x0C and config register at offset 0x10. Unused register bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| bus_evt | input | BUS_W | Bus event strobes, one cycle each |
| dma_evt | input | DMA_W | DMA event strobes, one cycle each |
| irq_pin | output | 1 | Interrupt pin |

## Verification
A status bit becomes readable right after the edge that samples its event or clear. The level-mode pin and the global-gate effect follow one edge later, because the pin stage registers the request. A pulse covers edges E+1 through E+PULSE_CYC after the request-setting edge E, and a polarity write moves the pin right after its own edge. The driver records the edge index of each stimulus and queues the expected pin level for each exact later edge. A monitor compares those levels 1 ns after the matching rising edge, and register reads are compared at the following falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  // register offsets (mode and config positions are fixed)
  localparam logic [AW-1:0] OFS_MODE   = 8'h0C;
  localparam logic [AW-1:0] OFS_CFG    = 8'h10;
  localparam logic [AW-1:0] OFS_BUS_EN = 8'h14;
  localparam logic [AW-1:0] OFS_BUS_ST = 8'h18;
  localparam logic [AW-1:0] OFS_DMA_EN = 8'h1C;
  localparam logic [AW-1:0] OFS_DMA_ST = 8'h20;

  // bit positions
  localparam int GEN_BIT   = 0;  // in mode register
  localparam int POL_BIT   = 0;  // in config register
  localparam int PULSE_BIT = 1;  // in config register

  typedef struct packed {
    logic gen;    // global enable
    logic pol;    // 1 = active high
    logic pulse;  // 1 = pulse signalling
  } irq_ctl_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         pending
);
  logic [W-1:0] status_q, status_d;

  // event has priority over a simultaneous clear
  always_comb begin
    status_d = (status_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status  = status_q;
  assign pending = |(status_q & mask);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((status_q & $past(clr & ~evt)) == '0));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt == '0) && (clr == '0)) |=> $stable(status_q));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DMA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [BUS_W-1:0] bus_status,
  input  logic [DMA_W-1:0] dma_status,
  output irq_ctl_t         ctl,
  output logic [BUS_W-1:0] bus_mask,
  output logic [DMA_W-1:0] dma_mask,
  output logic [BUS_W-1:0] bus_clr,
  output logic [DMA_W-1:0] dma_clr,
  output logic [DW-1:0]    rdata
);
  irq_ctl_t         ctl_q, ctl_d;
  logic [BUS_W-1:0] bus_mask_q, bus_mask_d;
  logic [DMA_W-1:0] dma_mask_q, dma_mask_d;
  logic             we;

  assign we = sel & wr;

  always_comb begin
    ctl_d      = ctl_q;
    bus_mask_d = bus_mask_q;
    dma_mask_d = dma_mask_q;
    bus_clr    = '0;
    dma_clr    = '0;
    if (we) begin
      unique case (addr)
        OFS_MODE:   ctl_d.gen = wdata[GEN_BIT];
        OFS_CFG: begin
          ctl_d.pol   = wdata[POL_BIT];
          ctl_d.pulse = wdata[PULSE_BIT];
        end
        OFS_BUS_EN: bus_mask_d = wdata[BUS_W-1:0];
        OFS_DMA_EN: dma_mask_d = wdata[DMA_W-1:0];
        OFS_BUS_ST: bus_clr    = wdata[BUS_W-1:0];
        OFS_DMA_ST: dma_clr    = wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      bus_mask_q <= '0;
      dma_mask_q <= '0;
    end else begin
      ctl_q      <= ctl_d;
      bus_mask_q <= bus_mask_d;
      dma_mask_q <= dma_mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_MODE:   rdata[GEN_BIT] = ctl_q.gen;
      OFS_CFG: begin
        rdata[POL_BIT]   = ctl_q.pol;
        rdata[PULSE_BIT] = ctl_q.pulse;
      end
      OFS_BUS_EN: rdata[BUS_W-1:0] = bus_mask_q;
      OFS_DMA_EN: rdata[DMA_W-1:0] = dma_mask_q;
      OFS_BUS_ST: rdata[BUS_W-1:0] = bus_status;
      OFS_DMA_ST: rdata[DMA_W-1:0] = dma_status;
      default: ;
    endcase
  end

  assign ctl      = ctl_q;
  assign bus_mask = bus_mask_q;
  assign dma_mask = dma_mask_q;
endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper #(
  parameter int PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gen,
  input  logic pulse_mode,
  input  logic pol,
  output logic pin
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic          req_c;
  logic          req_q, req_d;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          active;

  assign req_c = gen & req;

  always_comb begin
    req_d = req_c;
    lvl_d = req_c;
    cnt_d = cnt_q;
    if (!gen)
      cnt_d = '0;
    else if (pulse_mode && req_c && !req_q)
      cnt_d = CW'(PULSE_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = pulse_mode ? (cnt_q != '0) : lvl_q;
  assign pin    = pol ? active : ~active;

  assert_gate_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !active);

  assert_one_pulse_per_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(PULSE_CYC)) |-> $rose(req_q));

  assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && $stable(pulse_mode) && gen && $past(gen) && $past(req)) |-> active);
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
  import irq_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int DMA_W     = 8,
  parameter int PULSE_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [BUS_W-1:0] bus_evt,
  input  logic [DMA_W-1:0] dma_evt,
  output logic             irq_pin
);
  logic             rst_meta, rst_sync;
  irq_ctl_t         ctl;
  logic [BUS_W-1:0] bus_mask, bus_clr, bus_status;
  logic [DMA_W-1:0] dma_mask, dma_clr, dma_status;
  logic             bus_pend, dma_pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  irq_regs #(.BUS_W(BUS_W), .DMA_W(DMA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .sel(reg_sel), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .bus_status(bus_status), .dma_status(dma_status),
    .ctl(ctl), .bus_mask(bus_mask), .dma_mask(dma_mask),
    .bus_clr(bus_clr), .dma_clr(dma_clr), .rdata(reg_rdata)
  );

  irq_status_bank #(.W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_sync), .evt(bus_evt), .clr(bus_clr),
    .mask(bus_mask), .status(bus_status), .pending(bus_pend)
  );

  irq_status_bank #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_sync), .evt(dma_evt), .clr(dma_clr),
    .mask(dma_mask), .status(dma_status), .pending(dma_pend)
  );

  irq_pin_shaper #(.PULSE_CYC(PULSE_CYC)) u_shape (
    .clk(clk), .rst_n(rst_sync), .req(bus_pend | dma_pend),
    .gen(ctl.gen), .pulse_mode(ctl.pulse), .pol(ctl.pol), .pin(irq_pin)
  );
endmodule

// File: tb/sim_irq_pin_gen.sv
`timescale 1ns/1ps
module sim_irq_pin_gen;
  import irq_pkg::*;
  localparam int PW = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] bus_evt, dma_evt;
  logic       irq_pin;

  always #2.5 clk = ~clk;

  irq_pin_gen #(.BUS_W(8), .DMA_W(8), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_evt(bus_evt), .dma_evt(dma_evt), .irq_pin(irq_pin)
  );

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   pol = 1'b0;
  int   e;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void push_pin(int at, bit active, string tag);
    exp_t it;
    it.at  = at;
    it.val = pol ? active : ~active;
    it.tag = tag;
    q.push_back(it);
  endfunction

  // monitor: compares the pin 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t it;
      it = q.pop_front();
      if (it.at < cyc) check({it.tag, " missed"}, 0, 1);
      else             check(it.tag, {31'd0, irq_pin}, {31'd0, it.val});
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic fire(logic [7:0] b, logic [7:0] d);
    @(negedge clk);
    bus_evt = b; dma_evt = d;
    @(negedge clk);
    bus_evt = '0; dma_evt = '0;
  endtask

  task automatic wr_fire(logic [7:0] a, logic [7:0] w, logic [7:0] b);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = w; bus_evt = b;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; bus_evt = '0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    bus_evt = '0; dma_evt = '0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1 reset state
    check("R1 pin idle high", {31'd0, irq_pin}, 1);
    rd_chk(OFS_MODE,   0, "R1 mode");
    rd_chk(OFS_CFG,    0, "R1 cfg");
    rd_chk(OFS_BUS_EN, 0, "R1 bus en");
    rd_chk(OFS_BUS_ST, 0, "R1 bus st");
    rd_chk(OFS_DMA_EN, 0, "R1 dma en");
    rd_chk(OFS_DMA_ST, 0, "R1 dma st");

    wr_reg(OFS_BUS_EN, 8'h01);
    wr_reg(OFS_DMA_EN, 8'h04);
    rd_chk(OFS_BUS_EN, 8'h01, "R4 bus mask readback");

    // R5: global enable off, pin stays idle
    fire(8'h01, 0); e = cyc;
    rd_chk(OFS_BUS_ST, 8'h01, "R2 bus bit0 set");
    push_pin(e + 1, 0, "R5 gated off");
    push_pin(e + 2, 0, "R5 gated off");
    idle(3);

    wr_reg(OFS_MODE, 8'h01); e = cyc;
    rd_chk(OFS_MODE, 8'h01, "R10 mode offset");
    push_pin(e + 1, 1, "R6 level assert");
    push_pin(e + 2, 1, "R6 level hold");
    idle(2);

    fire(8'h02, 0);
    rd_chk(OFS_BUS_ST, 8'h03, "R2 bus bit1 set");
    wr_reg(OFS_BUS_ST, 8'h00);
    rd_chk(OFS_BUS_ST, 8'h03, "R3 write zero no effect");
    wr_reg(OFS_BUS_ST, 8'h01); e = cyc;
    rd_chk(OFS_BUS_ST, 8'h02, "R3 w1c clears");
    push_pin(e + 1, 0, "R6 level deassert");
    push_pin(e + 2, 0, "R4 masked bit keeps idle");
    idle(3);

    // R3: event and clear in the same cycle
    wr_fire(OFS_BUS_ST, 8'h01, 8'h01); e = cyc;
    rd_chk(OFS_BUS_ST, 8'h03, "R3 event beats clear");
    push_pin(e + 1, 1, "R3 event beats clear pin");
    idle(2);
    wr_reg(OFS_BUS_ST, 8'hFF); e = cyc;
    rd_chk(OFS_BUS_ST, 8'h00, "R3 clear all");
    push_pin(e + 1, 0, "R6 deassert after clear");
    idle(2);

    // DMA group
    fire(0, 8'h04); e = cyc;
    rd_chk(OFS_DMA_ST, 8'h04, "R2 dma bit2 set");
    push_pin(e + 1, 1, "R6 dma level assert");
    idle(2);
    fire(0, 8'h08);
    wr_reg(OFS_DMA_ST, 8'h04); e = cyc;
    rd_chk(OFS_DMA_ST, 8'h08, "R3 dma w1c");
    push_pin(e + 1, 0, "R4 dma masked bit");
    idle(3);
    wr_reg(OFS_DMA_ST, 8'h08);

    // R5: disabling while pending
    fire(8'h01, 0); e = cyc;
    push_pin(e + 1, 1, "R6 assert before disable");
    idle(2);
    wr_reg(OFS_MODE, 8'h00); e = cyc;
    push_pin(e + 1, 0, "R5 disable idles pin");
    push_pin(e + 2, 0, "R5 disable idles pin");
    idle(3);
    wr_reg(OFS_BUS_ST, 8'h01);
    wr_reg(OFS_MODE, 8'h01);

    // R7 pulse mode
    wr_reg(OFS_CFG, 8'h02);
    rd_chk(OFS_CFG, 8'h02, "R10 cfg offset");
    idle(2);
    fire(8'h01, 0); e = cyc;
    for (int k = 1; k <= PW; k++) push_pin(e + k, 1, "R7 pulse active");
    push_pin(e + PW + 1, 0, "R7 pulse end");
    idle(PW + 3);

    // R8: request stays high, no new pulse
    wr_reg(OFS_BUS_EN, 8'h03);
    fire(8'h02, 0); e = cyc;
    for (int k = 1; k <= PW + 2; k++) push_pin(e + k, 0, "R8 no repeat");
    idle(PW + 3);
    wr_reg(OFS_BUS_ST, 8'h03); e = cyc;
    push_pin(e + 1, 0, "R8 request low");
    idle(2);
    fire(8'h02, 0); e = cyc;
    for (int k = 1; k <= PW; k++) push_pin(e + k, 1, "R8 new pulse");
    push_pin(e + PW + 1, 0, "R8 new pulse end");
    idle(PW + 3);
    wr_reg(OFS_BUS_ST, 8'h03);
    idle(2);

    // R9 polarity
    wr_reg(OFS_CFG, 8'h01); pol = 1;
    check("R9 idle low when active high", {31'd0, irq_pin}, 0);
    idle(1);
    fire(8'h01, 0); e = cyc;
    push_pin(e + 1, 1, "R9 active high assert");
    idle(2);
    wr_reg(OFS_CFG, 8'h00); pol = 0;
    check("R9 flip while active", {31'd0, irq_pin}, 0);
    idle(1);
    wr_reg(OFS_BUS_ST, 8'h01); e = cyc;
    push_pin(e + 1, 0, "R9 idle high after clear");
    idle(4);

    finish_run();
  end
endmodule